// File: doc/BRIEF.md
# Multiplexed External Memory Bus Controller

This block turns single table-read and table-write requests from inside the chip into accesses on an external parallel memory bus. Address and data share the same pins. Static configuration inputs pick the data width (8 or 16 bits) and the address width (8, 12, 16 or 20 bits). They also turn wait states on or off and set how many there are. Pins above the chosen address width are handed back to general I/O, and the bus never drives them.

One access takes one instruction cycle, which is four clocks long. After it come zero to three extra instruction cycles of wait states. The first clock is the address phase: the word address is driven with a one-cycle address-latch strobe. The remaining clocks are the data phase. A write drives the write data with a write strobe. A read releases the data lines with a read strobe and samples them on the last clock. Address-only lines hold the address for the whole access.

A byte-address output and two byte selects give byte addressing. In 20-bit mode, the byte-address output carries address bit 0, so the bus reaches a 21-bit byte space. Completion is reported by a one-cycle done pulse, which carries the read data.

The sequencer has four states:
- IDLE: ready for a request. IDLE goes to ADDR when a request is accepted.
- ADDR: one clock. ADDR always goes to DATA.
- DATA: three clocks. DATA goes to WAIT when the wait count is non-zero; otherwise it goes to IDLE and raises done.
- WAIT: four clocks per wait cycle. WAIT goes to IDLE and raises done.

Top module: `emb_bus_ctrl`

## Requirements
- R1: After reset, every pin_oe bit is 0. The signals ale, rd_stb, wr_stb, ub_sel, lb_sel, ba0 and done are 0, and req_ready is 1.
- R2: The address-width code is decoded as 2'b00=8, 2'b01=12, 2'b10=16 and 2'b11=20 lines. Bit i of pin_free is 1 exactly when i is at or above the address width. pin_free depends only on the configuration.
- R3: No pin whose pin_free bit is 1 ever has its pin_oe bit set.
- R4: The clock after a request is accepted is the address phase. In that clock, ale is 1 for exactly one cycle, and pin_oe equals the owned-line mask. pin_out bit i carries req_addr[i+1] on every owned line, so the pins carry the word address.
- R5: In the data phase of a write, wr_stb is 1 and pin_oe equals the owned mask. Data lines carry req_wdata. Data lines are the lines below both the data width and the address width. Address-only lines keep the address.
- R6: In the data phase of a read, rd_stb is 1 and pin_oe is 0 on every data line. Pins are sampled on the last clock of the access. done is then a one-cycle pulse, and rd_data holds pin_in on the data lines and 0 on every other bit.
- R7: The effective wait count W is cfg_wait_cnt when cfg_wait_en is 1, and 0 otherwise. done is high in the cycle after the (4+4W)-th rising edge that follows the accepting edge.
- R8: With 8-bit data, lines 15:8 that lie inside the address width carry only address during the whole access, and rd_data[15:8] is 0.
- R9: cfg_bad is 1 exactly when 16-bit data is selected with an 8- or 12-bit address width. In that case, the data bits above the address width read back as 0.
- R10: During an access, ba0 equals req_addr[0] in 20-bit mode and is 0 in every other mode. With 16-bit data, a word access sets ub_sel and lb_sel both to 1. A byte access sets ub_sel to req_addr[0] and lb_sel to its inverse. With 8-bit data, lb_sel is 1 and ub_sel is 0. Outside an access, all three are 0.
- R11: req_ready is 1 only in the idle state. It is 0 from the clock after acceptance until the access completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wide | input | 1 | 1 selects 16-bit data, 0 selects 8-bit data |
| cfg_aw_code | input | 2 | Address-width code |
| cfg_wait_en | input | 1 | Turns wait states on |
| cfg_wait_cnt | input | 2 | Wait instruction cycles when enabled |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 selects write, 0 selects read |
| req_byte | input | 1 | Byte access in 16-bit mode |
| req_addr | input | 21 | Byte address |
| req_wdata | input | 16 | Write data |
| req_ready | output | 1 | Idle, a request may be accepted |
| pin_in | input | 16 | Values read from the multiplexed lines |
| pin_out | output | 20 | Values driven on the bus lines |
| pin_oe | output | 20 | Output enables for the bus lines |
| pin_free | output | 20 | Lines released to general I/O |
| cfg_bad | output | 1 | Address width narrower than data width |
| ale | output | 1 | Address-latch strobe |
| rd_stb | output | 1 | Read strobe |
| wr_stb | output | 1 | Write strobe |
| ub_sel | output | 1 | Upper-byte select |
| lb_sel | output | 1 | Lower-byte select |
| ba0 | output | 1 | Byte-address line |
| rd_data | output | 16 | Returned read data |
| done | output | 1 | Access complete, one cycle |

## Verification
The assertions check four things on every cycle. Released pins are never enabled. ale and done never last more than one cycle. The read, write and latch strobes never overlap. The data lines are released while rd_stb is high.

Only the bench scenarios show the value-level behaviour. This covers the pin contents in each phase and the latency for each wait setting. It also covers the masking of read data under the 8-bit and invalid width configurations and the byte-select and ba0 values. The bench checks these across several width combinations.

// File: rtl/emb_pkg.sv
package emb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_DATA = 2'd2,
        ST_WAIT = 2'd3
    } emb_state_t;
endpackage

// File: rtl/emb_width_map.sv
module emb_width_map #(
    parameter int PIN_W  = 20,
    parameter int DATA_W = 16
) (
    input  logic             cfg_wide,
    input  logic [1:0]       cfg_aw_code,
    output logic [PIN_W-1:0] own_mask,
    output logic [PIN_W-1:0] data_mask,
    output logic [PIN_W-1:0] free_mask,
    output logic             cfg_bad,
    output logic             aw_full
);
    localparam int LW = $clog2(PIN_W + 1);

    logic [LW-1:0] aw_lines;
    logic [LW-1:0] dw_lines;

    // R2: 8 + 4*code lines
    assign aw_lines = LW'(8) + LW'({cfg_aw_code, 2'b00});
    assign dw_lines = cfg_wide ? LW'(DATA_W) : LW'(DATA_W / 2);
    assign aw_full  = (cfg_aw_code == 2'b11);
    assign cfg_bad  = cfg_wide && (aw_lines < LW'(DATA_W));   // R9

    for (genvar i = 0; i < PIN_W; i++) begin : g_line
        assign own_mask[i]  = LW'(i) < aw_lines;
        assign data_mask[i] = own_mask[i] && (LW'(i) < dw_lines);
        assign free_mask[i] = !own_mask[i];
    end
endmodule

// File: rtl/emb_fsm.sv
module emb_fsm
    import emb_pkg::*;
#(
    parameter int PIN_W  = 20,
    parameter int DATA_W = 16,
    parameter int PHASES = 4,
    parameter int WAIT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_byte,
    input  logic [PIN_W:0]    req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [WAIT_W-1:0] wait_cycles,
    input  logic [PIN_W-1:0]  own_mask,
    input  logic [PIN_W-1:0]  data_mask,
    input  logic              cfg_wide,
    input  logic              aw_full,
    input  logic [DATA_W-1:0] pin_in,
    output logic              req_ready,
    output logic [PIN_W-1:0]  pin_out,
    output logic [PIN_W-1:0]  pin_oe,
    output logic              ale,
    output logic              rd_stb,
    output logic              wr_stb,
    output logic              ub_sel,
    output logic              lb_sel,
    output logic              ba0,
    output logic [DATA_W-1:0] rd_data,
    output logic              done
);
    localparam int CNT_W = $clog2(((1 << WAIT_W) - 1) * PHASES + 1);

    emb_state_t        state_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [PIN_W:0]    addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic              write_q;
    logic              byte_q;
    logic [WAIT_W-1:0] wait_q;

    logic [PIN_W-1:0]  addr_word;
    logic [PIN_W-1:0]  addr_only;
    logic [PIN_W-1:0]  wdata_ext;

    assign addr_word = addr_q[PIN_W:1];
    assign addr_only = own_mask & ~data_mask;
    assign wdata_ext = PIN_W'(wdata_q);

    // state register, counters and returned data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
            write_q <= 1'b0;
            byte_q  <= 1'b0;
            wait_q  <= '0;
            done    <= 1'b0;
            rd_data <= '0;
        end else begin
            done <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        addr_q  <= req_addr;
                        wdata_q <= req_wdata;
                        write_q <= req_write;
                        byte_q  <= req_byte;
                        wait_q  <= wait_cycles;
                        state_q <= ST_ADDR;
                    end
                end
                ST_ADDR: begin
                    state_q <= ST_DATA;
                    cnt_q   <= CNT_W'(PHASES - 2);
                end
                ST_DATA: begin
                    if (cnt_q != '0) begin
                        cnt_q <= cnt_q - 1'b1;
                    end else if (wait_q != '0) begin
                        state_q <= ST_WAIT;
                        cnt_q   <= CNT_W'(int'(wait_q) * PHASES - 1);
                    end else begin
                        state_q <= ST_IDLE;
                        done    <= 1'b1;
                        if (!write_q) rd_data <= pin_in & data_mask[DATA_W-1:0];
                    end
                end
                ST_WAIT: begin
                    if (cnt_q != '0) begin
                        cnt_q <= cnt_q - 1'b1;
                    end else begin
                        state_q <= ST_IDLE;
                        done    <= 1'b1;
                        if (!write_q) rd_data <= pin_in & data_mask[DATA_W-1:0];
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // pin and strobe outputs
    always_comb begin
        req_ready = (state_q == ST_IDLE);
        pin_out   = '0;
        pin_oe    = '0;
        ale       = 1'b0;
        rd_stb    = 1'b0;
        wr_stb    = 1'b0;
        ub_sel    = 1'b0;
        lb_sel    = 1'b0;
        ba0       = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
            end
            ST_ADDR: begin
                pin_out = addr_word & own_mask;
                pin_oe  = own_mask;
                ale     = 1'b1;
            end
            ST_DATA, ST_WAIT: begin
                if (write_q) begin
                    pin_out = (wdata_ext & data_mask) | (addr_word & addr_only);
                    pin_oe  = own_mask;
                    wr_stb  = 1'b1;
                end else begin
                    pin_out = addr_word & addr_only;
                    pin_oe  = addr_only;
                    rd_stb  = 1'b1;
                end
            end
            default: begin
            end
        endcase
        if (state_q != ST_IDLE) begin
            ba0 = aw_full & addr_q[0];
            if (cfg_wide) begin
                ub_sel = byte_q ? addr_q[0]  : 1'b1;
                lb_sel = byte_q ? ~addr_q[0] : 1'b1;
            end else begin
                lb_sel = 1'b1;
            end
        end
    end

    AST_ALE_PULSE:      assert property (@(posedge clk) disable iff (!rst_n) ale |=> !ale);  // R4
    AST_DONE_PULSE:     assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R6
    AST_STROBE_EXCL:    assert property (@(posedge clk) disable iff (!rst_n)
                            !(rd_stb && wr_stb) && !(ale && (rd_stb || wr_stb)));          // R5
    AST_READ_HIZ:       assert property (@(posedge clk) disable iff (!rst_n)
                            rd_stb |-> ((pin_oe & data_mask) == '0));                      // R6
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
                            (ale || rd_stb || wr_stb) |-> !req_ready);                     // R11
endmodule

// File: rtl/emb_bus_ctrl.sv
module emb_bus_ctrl #(
    parameter int PIN_W  = 20,
    parameter int DATA_W = 16,
    parameter int PHASES = 4,
    parameter int WAIT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wide,
    input  logic [1:0]        cfg_aw_code,
    input  logic              cfg_wait_en,
    input  logic [WAIT_W-1:0] cfg_wait_cnt,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_byte,
    input  logic [PIN_W:0]    req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    input  logic [DATA_W-1:0] pin_in,
    output logic [PIN_W-1:0]  pin_out,
    output logic [PIN_W-1:0]  pin_oe,
    output logic [PIN_W-1:0]  pin_free,
    output logic              cfg_bad,
    output logic              ale,
    output logic              rd_stb,
    output logic              wr_stb,
    output logic              ub_sel,
    output logic              lb_sel,
    output logic              ba0,
    output logic [DATA_W-1:0] rd_data,
    output logic              done
);
    logic [PIN_W-1:0]  own_mask;
    logic [PIN_W-1:0]  data_mask;
    logic              aw_full;
    logic [WAIT_W-1:0] wait_cycles;

    assign wait_cycles = cfg_wait_en ? cfg_wait_cnt : '0;   // R7

    emb_width_map #(.PIN_W(PIN_W), .DATA_W(DATA_W)) u_map (
        .cfg_wide    (cfg_wide),
        .cfg_aw_code (cfg_aw_code),
        .own_mask    (own_mask),
        .data_mask   (data_mask),
        .free_mask   (pin_free),
        .cfg_bad     (cfg_bad),
        .aw_full     (aw_full)
    );

    emb_fsm #(.PIN_W(PIN_W), .DATA_W(DATA_W), .PHASES(PHASES), .WAIT_W(WAIT_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_write   (req_write),
        .req_byte    (req_byte),
        .req_addr    (req_addr),
        .req_wdata   (req_wdata),
        .wait_cycles (wait_cycles),
        .own_mask    (own_mask),
        .data_mask   (data_mask),
        .cfg_wide    (cfg_wide),
        .aw_full     (aw_full),
        .pin_in      (pin_in),
        .req_ready   (req_ready),
        .pin_out     (pin_out),
        .pin_oe      (pin_oe),
        .ale         (ale),
        .rd_stb      (rd_stb),
        .wr_stb      (wr_stb),
        .ub_sel      (ub_sel),
        .lb_sel      (lb_sel),
        .ba0         (ba0),
        .rd_data     (rd_data),
        .done        (done)
    );

    AST_FREE_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
                           (pin_oe & pin_free) == '0);   // R3
endmodule

// File: tb/sim_emb_bus_ctrl.sv
module sim_emb_bus_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wide = 1'b1;
    logic [1:0]  cfg_aw_code = 2'b11;
    logic        cfg_wait_en = 1'b1;
    logic [1:0]  cfg_wait_cnt = 2'd3;
    logic        req_valid = 1'b0, req_write = 1'b0, req_byte = 1'b0;
    logic [20:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [15:0] pin_in = '0;
    logic        req_ready, cfg_bad, ale, rd_stb, wr_stb, ub_sel, lb_sel, ba0, done;
    logic [19:0] pin_out, pin_oe, pin_free;
    logic [15:0] rd_data;

    typedef struct packed {
        logic [15:0] rdata;
        logic [31:0] acc;
        logic [31:0] lat;
        logic        is_rd;
    } exp_t;

    exp_t sb[$];
    int   nchk = 0, nfail = 0, cyc = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    emb_bus_ctrl u0 (.*);

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [19:0] f_own(input logic [1:0] code);
        return 20'((64'd1 << (8 + 4 * int'(code))) - 1);
    endfunction

    function automatic logic [19:0] f_dmask(input logic wide, input logic [1:0] code);
        return f_own(code) & (wide ? 20'h0ffff : 20'h000ff);
    endfunction

    task automatic set_cfg(input logic wide, input logic [1:0] code, input logic wen, input logic [1:0] wc);
        @(negedge clk);
        cfg_wide = wide; cfg_aw_code = code; cfg_wait_en = wen; cfg_wait_cnt = wc;
        #1;
        chk(pin_free == ~f_own(code), "R2 pin_free", pin_free, ~f_own(code));
        chk(cfg_bad == (wide && code < 2'b10), "R9 cfg_bad", cfg_bad, wide && code < 2'b10);
    endtask

    task automatic do_access(input bit wr, input bit byt, input logic [20:0] a,
                             input logic [15:0] wd, input logic [15:0] rpat);
        logic [19:0] own, dm, aw, exp_out;
        int w;
        exp_t it;
        own = f_own(cfg_aw_code);
        dm  = f_dmask(cfg_wide, cfg_aw_code);
        aw  = a[20:1];
        w   = cfg_wait_en ? int'(cfg_wait_cnt) : 0;
        @(negedge clk);
        pin_in = rpat; req_write = wr; req_byte = byt; req_addr = a; req_wdata = wd;
        req_valid = 1'b1;
        chk(req_ready == 1'b1, "R11 ready idle", req_ready, 1);
        @(posedge clk);
        #1;
        it.acc = cyc; it.lat = 4 + 4 * w; it.is_rd = !wr;
        it.rdata = rpat & dm[15:0];
        sb.push_back(it);
        @(negedge clk);
        req_valid = 1'b0;
        // address phase
        chk(ale == 1'b1, "R4 ale", ale, 1);
        chk(pin_oe == own, "R4 oe", pin_oe, own);
        chk((pin_out & own) == (aw & own), "R4 addr", pin_out, aw & own);
        chk(ba0 == ((cfg_aw_code == 2'b11) ? a[0] : 1'b0), "R10 ba0", ba0, a[0]);
        chk(req_ready == 1'b0, "R11 busy", req_ready, 0);
        @(negedge clk);
        // data phase
        chk(ale == 1'b0, "R4 ale single", ale, 0);
        if (wr) begin
            exp_out = (20'(wd) & dm) | (aw & own & ~dm);
            chk(wr_stb == 1'b1 && rd_stb == 1'b0, "R5 wr_stb", wr_stb, 1);
            chk(pin_out == exp_out, "R5 wdata", pin_out, exp_out);
            chk(pin_oe == own, "R5 oe", pin_oe, own);
        end else begin
            chk(rd_stb == 1'b1 && wr_stb == 1'b0, "R6 rd_stb", rd_stb, 1);
            chk(pin_oe == (own & ~dm), "R6 oe", pin_oe, own & ~dm);
        end
        if (!cfg_wide)
            chk((pin_out & own & ~dm) == (aw & own & ~dm), "R8 addr-only lines", pin_out, aw & own & ~dm);
        if (cfg_wide)
            chk({ub_sel, lb_sel} == (byt ? {a[0], ~a[0]} : 2'b11), "R10 byte sel", {ub_sel, lb_sel},
                byt ? {a[0], ~a[0]} : 2'b11);
        else
            chk({ub_sel, lb_sel} == 2'b01, "R10 byte sel narrow", {ub_sel, lb_sel}, 2'b01);
        while (!done) @(negedge clk);
        @(negedge clk);
        chk(req_ready == 1'b1 && ub_sel == 1'b0 && lb_sel == 1'b0 && pin_oe == '0,
            "R10 idle after", {req_ready, ub_sel, lb_sel}, 3'b100);
    endtask

    // monitor: scoreboard compare
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (sb.size() == 0) begin
                chk(1'b0, "R6 unexpected done", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(32'(cyc) - e.acc == e.lat, "R7 latency", 32'(cyc) - e.acc, e.lat);
                if (e.is_rd)
                    chk(rd_data == e.rdata, "R6 R8 R9 rdata", rd_data, e.rdata);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog act=0 exp=1");
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(pin_oe == '0 && ale == 0 && rd_stb == 0 && wr_stb == 0, "R1 reset pins", pin_oe, 0);
        chk(done == 0 && ub_sel == 0 && lb_sel == 0 && ba0 == 0, "R1 reset strobes", done, 0);
        chk(req_ready == 1'b1, "R1 reset ready", req_ready, 1);
        rst_n = 1'b1;

        set_cfg(1'b1, 2'b11, 1'b1, 2'd3);
        do_access(1'b1, 1'b0, 21'h1a5a5b, 16'hbeef, 16'h0000);
        do_access(1'b0, 1'b0, 21'h0f0f0f, 16'h0000, 16'hc3a5);

        set_cfg(1'b1, 2'b11, 1'b0, 2'd3);
        do_access(1'b0, 1'b1, 21'h000001, 16'h0000, 16'h1234);

        set_cfg(1'b1, 2'b10, 1'b1, 2'd1);
        do_access(1'b1, 1'b1, 21'h012345, 16'h55aa, 16'h0000);
        do_access(1'b0, 1'b1, 21'h0abcd4, 16'h0000, 16'h8001);

        set_cfg(1'b0, 2'b01, 1'b1, 2'd2);
        do_access(1'b0, 1'b0, 21'h1fffff, 16'h0000, 16'hffff);
        do_access(1'b1, 1'b0, 21'h000ff6, 16'hff3c, 16'h0000);

        set_cfg(1'b1, 2'b00, 1'b1, 2'd0);
        do_access(1'b0, 1'b0, 21'h0003fe, 16'h0000, 16'hfedc);

        set_cfg(1'b0, 2'b00, 1'b0, 2'd2);
        do_access(1'b1, 1'b0, 21'h000155, 16'h9966, 16'h0000);
        do_access(1'b0, 1'b0, 21'h000155, 16'h0000, 16'h7e81);

        repeat (4) @(negedge clk);
        chk(sb.size() == 0, "R6 all done seen", sb.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule